// File: doc/BRIEF.md
# Short-Cycle Successive Approximation Sequencer

This block is the clocked digital half of a successive-approximation converter. A start pulse clears the trial code and sets its top bit. On every following clock the block reads a one-bit verdict from an external comparator. That verdict says whether the present trial code stays at or below the held input. The block then keeps or clears the bit under test and arms the next lower bit. The trial code drives an external DAC. The DAC, the comparator and the sample-and-hold all sit outside the block.

Each conversion picks its own length when it starts. A full conversion resolves every bit. A short conversion stops after the upper 8 bits and leaves the low bits at zero. A separate end-of-convert pulse marks each of the two lengths. The finished code goes into a result register that only changes when a conversion completes. Bus access and status timing belong to a neighbouring block.

Top module: `sar_seq_top`

## Requirements
- R1: A start pulse sampled while idle makes `busy` high from the next cycle. In that first busy cycle `dac_code` equals 12'h800: the trial register is cleared and only its top bit is set.
- R2: During a busy cycle, `cmp_keep`=1 keeps the bit under test set, and `cmp_keep`=0 clears it. `cmp_keep`=1 means the trial code does not exceed the input.
- R3: Bits are tested strictly from bit 11 down to bit 0, one bit per clock cycle.
- R4: With `short_sel`=0 at start, `busy` stays high for exactly 12 cycles. With `short_sel`=1 at start, it stays high for exactly 8 cycles.
- R5: `short_sel` is captured on the start cycle. Changing it during a conversion changes neither the length nor the result.
- R6: A start pulse that arrives while `busy` is high is ignored. It neither restarts the running conversion nor queues a new one.
- R7: In the cycle after the last bit decision, `busy` is low and one end-of-convert pulse lasts exactly one cycle. That pulse is `eoc_full` for a 12-bit conversion and `eoc_short` for an 8-bit one. The two are never high together.
- R8: When the end-of-convert pulse is high, `result` holds the converted code. For a full conversion this equals the comparator's target. For a short conversion it equals the target with bits 3..0 forced to zero.
- R9: `result` keeps its previous value for the whole of a conversion and changes only in the cycle that `eoc_full` or `eoc_short` is high.
- R10: After a synchronous reset (`rst_n` low at a clock edge), `busy`, `eoc_full`, `eoc_short`, `dac_code` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each tested bit takes one cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start request, sampled at a rising edge; ignored while busy |
| short_sel | input | 1 | 1 selects an 8-bit conversion, 0 a 12-bit one; sampled with start |
| cmp_keep | input | 1 | Comparator verdict: 1 when the trial code does not exceed the input |
| dac_code | output | 12 | Trial code for the external DAC |
| result | output | 12 | Last completed conversion result |
| busy | output | 1 | High while a conversion runs |
| eoc_full | output | 1 | One-cycle pulse when a 12-bit conversion completes |
| eoc_short | output | 1 | One-cycle pulse when an 8-bit conversion completes |

## Verification
The assertions assume that `cmp_keep` is a pure function of the present `dac_code` against an input that stays still for the whole conversion. They also assume that reset is held for at least two clock edges. The stimulus meets both conditions. The comparator is modelled as a continuous compare of `dac_code` with a target. That target is changed only while the block is idle, and reset is held for several cycles. Start pulses and changes to `short_sel` in the middle of a conversion are applied on purpose. They are harmless to these assumptions because the block must ignore them.

// File: rtl/sar_seq_pkg.sv
// Package: shared types for the successive-approximation sequencer.
// Assumes nothing beyond a synthesizable 1-bit enum encoding.
package sar_seq_pkg;
    // Conversion length, captured once per conversion.
    typedef enum logic {
        LEN_FULL  = 1'b0,
        LEN_SHORT = 1'b1
    } len_e;
endpackage

// File: rtl/sar_seq_ctrl.sv
// Control for the sequencer. It owns the busy state, a one-hot pointer to
// the bit under test and the captured conversion length. It also issues
// the end-of-convert pulses.
// Assumes: start is a synchronous request; SHORT_WIDTH < WIDTH.
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int WIDTH       = 12,
    parameter int SHORT_WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             short_sel,
    output logic             busy,
    output logic [WIDTH-1:0] bit_sel,
    output len_e             len_q,
    output logic             load,
    output logic             last_step,
    output logic             eoc_full,
    output logic             eoc_short
);
    localparam int         SHORT_LSB = WIDTH - SHORT_WIDTH;
    localparam logic [WIDTH-1:0] TOP_ONE = {1'b1, {(WIDTH-1){1'b0}}};

    // Accept a start only when idle.
    assign load = start && !busy;

    // The final decision falls on bit 0 or on the lowest bit of the short field.
    assign last_step = busy && ((len_q == LEN_SHORT) ? bit_sel[SHORT_LSB] : bit_sel[0]);

    // Advance the bit pointer, track busy and capture the length at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            bit_sel <= '0;
            len_q   <= LEN_FULL;
        end else if (load) begin
            busy    <= 1'b1;
            bit_sel <= TOP_ONE;
            len_q   <= short_sel ? LEN_SHORT : LEN_FULL;
        end else if (last_step) begin
            busy    <= 1'b0;
            bit_sel <= '0;
        end else if (busy) begin
            bit_sel <= bit_sel >> 1;
        end
    end

    // Single-cycle completion pulses, one per conversion length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoc_full  <= 1'b0;
            eoc_short <= 1'b0;
        end else begin
            eoc_full  <= last_step && (len_q == LEN_FULL);
            eoc_short <= last_step && (len_q == LEN_SHORT);
        end
    end
endmodule

// File: rtl/sar_seq_trial.sv
// Trial-code register. It is cleared to the top bit alone at start. On each
// busy cycle it keeps or clears the bit under test and arms the next lower bit.
// Assumes: bit_sel is one-hot while busy, supplied by the control block.
module sar_seq_trial #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             busy,
    input  logic             last_step,
    input  logic [WIDTH-1:0] bit_sel,
    input  logic             keep,
    output logic [WIDTH-1:0] trial,
    output logic [WIDTH-1:0] decided
);
    localparam logic [WIDTH-1:0] TOP_ONE = {1'b1, {(WIDTH-1){1'b0}}};

    // Code with the current bit settled by the comparator verdict.
    assign decided = (trial & ~bit_sel) | (keep ? bit_sel : '0);

    // Hold the trial code; arm the next bit unless this is the last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trial <= '0;
        end else if (load) begin
            trial <= TOP_ONE;
        end else if (busy) begin
            trial <= last_step ? decided : (decided | (bit_sel >> 1));
        end
    end
endmodule

// File: rtl/sar_seq_result.sv
// Result register: captures the settled code only on the final bit decision.
// Assumes: last_step is high for exactly one cycle per conversion.
module sar_seq_result #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             last_step,
    input  logic [WIDTH-1:0] decided,
    output logic [WIDTH-1:0] result
);
    // Update the stored result once per finished conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (last_step) begin
            result <= decided;
        end
    end
endmodule

// File: rtl/sar_seq_top.sv
// Top of the successive-approximation sequencer: control, trial register
// and result register. Conversion length is chosen per start.
// Assumes: cmp_keep reflects dac_code against a held input, combinationally.
module sar_seq_top
    import sar_seq_pkg::*;
#(
    parameter int WIDTH       = 12,
    parameter int SHORT_WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             short_sel,
    input  logic             cmp_keep,
    output logic [WIDTH-1:0] dac_code,
    output logic [WIDTH-1:0] result,
    output logic             busy,
    output logic             eoc_full,
    output logic             eoc_short
);
    logic [WIDTH-1:0] bit_sel;
    logic [WIDTH-1:0] decided;
    len_e             len_q;
    logic             load;
    logic             last_step;

    sar_seq_ctrl #(.WIDTH(WIDTH), .SHORT_WIDTH(SHORT_WIDTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .short_sel (short_sel),
        .busy      (busy),
        .bit_sel   (bit_sel),
        .len_q     (len_q),
        .load      (load),
        .last_step (last_step),
        .eoc_full  (eoc_full),
        .eoc_short (eoc_short)
    );

    sar_seq_trial #(.WIDTH(WIDTH)) u_trial (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .busy      (busy),
        .last_step (last_step),
        .bit_sel   (bit_sel),
        .keep      (cmp_keep),
        .trial     (dac_code),
        .decided   (decided)
    );

    sar_seq_result #(.WIDTH(WIDTH)) u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .last_step (last_step),
        .decided   (decided),
        .result    (result)
    );
endmodule

// File: rtl/sar_seq_chk.sv
// Checker for the sequencer, attached to the top with bind.
// Assumes reset is held for at least two edges before release.
module sar_seq_chk #(
    parameter int WIDTH       = 12,
    parameter int SHORT_WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic [WIDTH-1:0] bit_sel,
    input logic [WIDTH-1:0] dac_code,
    input logic [WIDTH-1:0] result,
    input logic             eoc_full,
    input logic             eoc_short,
    input logic             len_q
);
    localparam int RL_W = $clog2(WIDTH + 1) + 1;
    localparam int SHORT_LSB = WIDTH - SHORT_WIDTH;

    logic [RL_W-1:0] run_len;

    // Count busy cycles of the current conversion; clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    a_r1_top_bit_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> dac_code == {1'b1, {(WIDTH-1){1'b0}}});

    a_r3_one_hot_walk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $onehot(bit_sel));

    a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> bit_sel == ($past(bit_sel) >> 1));

    a_r4_full_length: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_full |-> run_len == RL_W'(WIDTH));

    a_r4_short_length: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_short |-> run_len == RL_W'(SHORT_WIDTH));

    a_r5_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> $stable(len_q));

    a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> !(busy && bit_sel[WIDTH-1]));

    a_r7_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eoc_full, eoc_short}) && ((eoc_full || eoc_short) -> !busy));

    a_r7_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc_full || eoc_short) |=> !(eoc_full || eoc_short));

    a_r8_short_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_short |-> result[SHORT_LSB-1:0] == '0);

    a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(eoc_full || eoc_short) |-> $stable(result));
endmodule

bind sar_seq_top sar_seq_chk #(.WIDTH(WIDTH), .SHORT_WIDTH(SHORT_WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .bit_sel   (bit_sel),
    .dac_code  (dac_code),
    .result    (result),
    .eoc_full  (eoc_full),
    .eoc_short (eoc_short),
    .len_q     (len_q)
);

// File: tb/tb_sar_seq_top.sv
// Scoreboard bench: the driver queues expected results, the monitor pops them on completion.
module tb_sar_seq_top;
    localparam int W = 12;

    typedef struct packed {
        logic [W-1:0] code;
        logic         is_short;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         short_sel = 1'b0;
    logic [W-1:0] target = '0;
    logic         cmp_keep;
    logic [W-1:0] dac_code, result;
    logic         busy, eoc_full, eoc_short;

    int    checks = 0;
    int    fails = 0;
    bit    done = 0;
    exp_t  sb[$];
    logic [W-1:0] last_res = '0;

    always #5 clk = ~clk;

    // Behavioural comparator: keep when the trial does not exceed the target.
    assign cmp_keep = (dac_code <= target);

    sar_seq_top dut (
        .clk(clk), .rst_n(rst_n), .start(start), .short_sel(short_sel),
        .cmp_keep(cmp_keep), .dac_code(dac_code), .result(result),
        .busy(busy), .eoc_full(eoc_full), .eoc_short(eoc_short)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compares completions against the scoreboard, and result hold during busy.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (eoc_full || eoc_short) begin
                if (sb.size() == 0) begin
                    chk(0, "R6 unexpected completion", int'(result), 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(result == e.code, "R8 R2 result", int'(result), int'(e.code));
                    chk(eoc_short == e.is_short && eoc_full == !e.is_short,
                        "R7 eoc kind", int'({eoc_full, eoc_short}), int'({!e.is_short, e.is_short}));
                    chk(!busy, "R7 busy low at eoc", int'(busy), 0);
                end
                last_res = result;
            end else if (busy) begin
                chk(result == last_res, "R9 result held", int'(result), int'(last_res));
            end
        end
    end

    task automatic run_conv(input logic [W-1:0] tgt, input bit sm, input bit poke);
        exp_t e;
        int   len;
        @(negedge clk);
        target    = tgt;
        short_sel = sm;
        start     = 1'b1;
        e.code     = sm ? (tgt & 12'hFF0) : tgt;
        e.is_short = sm;
        sb.push_back(e);
        @(negedge clk);
        start = 1'b0;
        chk(busy && dac_code == 12'h800, "R1 start clears trial", int'(dac_code), 12'h800);
        len = 1;
        while (busy) begin
            if (poke) begin
                short_sel = ~sm;
                start     = (len == 3);
            end
            @(negedge clk);
            if (busy) len++;
        end
        start = 1'b0;
        // R3 R4 R5: one bit per cycle, length fixed by the captured select
        chk(len == (sm ? 8 : 12), "R4 R5 length", len, sm ? 8 : 12);
        if (poke) begin
            @(negedge clk);
            @(negedge clk);
            chk(!busy && !eoc_full && !eoc_short, "R6 ignored start", int'(busy), 0);
        end
        short_sel = 1'b0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(!busy && !eoc_full && !eoc_short && dac_code == 0 && result == 0,
            "R10 reset state", int'({busy, eoc_full, eoc_short}), 0);
        rst_n = 1'b1;
        run_conv(12'h000, 0, 0);
        run_conv(12'hFFF, 0, 0);
        run_conv(12'h800, 0, 0);
        run_conv(12'h7FF, 0, 0);
        run_conv(12'hFFF, 1, 0);
        run_conv(12'h00F, 1, 0);
        run_conv(12'hA5C, 0, 1);
        run_conv(12'h3B7, 1, 1);
        for (int i = 0; i < 40; i++) begin
            run_conv(W'($urandom), 1'($urandom), (i % 7) == 0);
        end
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R7 all completions seen", sb.size(), 0);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog R4 actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule